// File: doc/BRIEF.md
# Segment Trim Self-Calibration Sequencer

This block runs an on-chip self-calibration of the linearity trim words of a segmented current-steering converter. It walks the segment trims one after another: the 127 major segments and the single trim that balances the combined lower segments against one major segment. For each segment it pulls that segment off the output and searches the segment's 6-bit trim code against a reference current. The only feedback is a 1-bit comparator. It then stores the result in the working coefficient array and moves to the next segment, which puts the previous segment back on the output.

One trim step is worth roughly a quarter of a main-converter LSB, and the full trim range is about 16 LSBs. Every search step is paced by a divided calibration clock. While a run is in progress the converter output is not valid, so the block raises a blanking flag for the whole run. Software starts a run by setting and then clearing a control bit, and it reads completion from a done bit. At the end of a run the block writes the shared memory-state code with the value that means "self-calibrated". The four full-scale gain trims share the coefficient array, and the block never touches them. A host port reads and writes the array while the block is idle.

Top module: `selfcal_seq`

## Requirements
- R1: After reset `busy`, `done`, `blank` and `mstate_wr` are 0, and every coefficient word at addresses 1 to 132 reads 0.
- R2: A run starts only when `cal_go` is sampled high on one clock edge and low on the next while the block is idle. From the following edge onward `busy` and `blank` are 1 and `done` is 0. The segment under test `seg_idx` is 1 and `trim_code` is 32 (6'b100000).
- R3: A high-then-low pulse on `cal_go` while `busy` is 1 is ignored, and the run length does not change.
- R4: The calibration clock period is P = 32 << `div_sel` cycles. A trial code is held for one settle period before it is sampled, and `trim_code` changes only on a calibration clock tick.
- R5: Each segment gets a 6-step successive-approximation search, MSB first. A step keeps its trial bit when `cmp_low` = 1 (segment current below reference). The stored result is the largest code for which `cmp_low` reads 1, and it is written to address `seg_idx`.
- R6: Segments are handled one at a time in the order 1, 2, … 128. Each takes 12 ticks (12·P cycles), and `seg_idx` only ever steps up by one.
- R7: Exactly 1536·P cycles after the start edge, `busy` and `blank` fall and `done` rises. `mstate_wr` pulses for one cycle with `mstate_code` = 2'b01, and `done` stays 1 until the next run starts.
- R8: Gain trim words (addresses 129 to 132) keep their values across a run, and a host write during a run has no effect.
- R9: When the block is idle, a host write to an address from 1 to 132 is stored and read back. Writes to address 0 or to addresses above 132 are dropped, and those addresses read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Converter-domain clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cal_go | input | 1 | Calibration control bit; a high-then-low sequence starts a run |
| div_sel | input | 3 | Calibration clock divider select, period 32 << div_sel |
| cmp_low | input | 1 | Comparator: 1 when segment current is below reference |
| host_we | input | 1 | Host write strobe for the coefficient array |
| host_addr | input | 8 | Host write address |
| host_wdata | input | 6 | Host write data |
| rd_addr | input | 8 | Coefficient read address |
| rd_data | output | 6 | Coefficient read data (combinational) |
| busy | output | 1 | Run in progress |
| done | output | 1 | Completion status bit |
| blank | output | 1 | Output data invalid while a segment is removed |
| seg_idx | output | 8 | Address of the segment currently disconnected |
| trim_code | output | 6 | Trial trim code driven to the segment's trim converter |
| mstate_wr | output | 1 | One-cycle write strobe for the memory-state code |
| mstate_code | output | 2 | Memory-state value written (2'b01) |

## Verification
The start edge E0 is the clock edge on which `cal_go` is seen low after being seen high. `busy` is due right after E0, and the n-th calibration tick lands on edge E0 + n·P. The second tick of the first segment therefore changes bit 4 of `trim_code` at E0 + 2·P, the segment index advances at E0 + 12·P, and `done` rises at E0 + 1536·P. The bench counts edges from E0 and samples 1 ns after the edge at exactly these offsets and one cycle before each of them, for both P = 32 and P = 64. Coefficient reads are combinational and are checked between edges.

// File: rtl/scal_pkg.sv
package scal_pkg;
  localparam int TRIM_W = 6;
  localparam int BIT_W  = $clog2(TRIM_W);
  localparam logic [TRIM_W-1:0] SAR_FIRST = TRIM_W'(1) << (TRIM_W - 1);
  localparam logic [1:0] MSTATE_SELF = 2'b01;

  typedef enum logic {PH_SETTLE = 1'b0, PH_SAMPLE = 1'b1} phase_e;

  // One search step: drop the tested bit unless kept, then raise the next trial bit.
  function automatic logic [TRIM_W-1:0] sar_update(input logic [TRIM_W-1:0] c,
                                                   input logic [BIT_W-1:0]  b,
                                                   input logic              keep);
    logic [TRIM_W-1:0] mask;
    mask = TRIM_W'(1) << b;
    return (keep ? c : (c & ~mask)) | (mask >> 1);
  endfunction
endpackage

// File: rtl/scal_tick.sv
module scal_tick #(
  parameter int BASE_LOG = 5,
  parameter int SEL_W    = 3,
  localparam int CNT_W   = BASE_LOG + (1 << SEL_W) - 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [SEL_W-1:0] sel,
  output logic             tick
);
  logic [CNT_W-1:0] cnt;

  function automatic logic [CNT_W-1:0] period_last(input logic [SEL_W-1:0] s);
    return (CNT_W'(1) << (BASE_LOG + int'(s))) - CNT_W'(1);
  endfunction

  assign tick = run && (cnt == period_last(sel));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          cnt <= '0;
    else if (!run || tick) cnt <= '0;
    else                 cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/scal_sar.sv
module scal_sar
  import scal_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic              tick,
  input  logic              cmp_low,
  output logic [TRIM_W-1:0] code,
  output logic [TRIM_W-1:0] final_code,
  output logic              finish
);
  phase_e           phase;
  logic [BIT_W-1:0] bitpos;

  assign final_code = sar_update(code, bitpos, cmp_low);
  assign finish     = tick && (phase == PH_SAMPLE) && (bitpos == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      code   <= '0;
      bitpos <= '0;
      phase  <= PH_SETTLE;
    end else if (load) begin
      code   <= SAR_FIRST;
      bitpos <= BIT_W'(TRIM_W - 1);
      phase  <= PH_SETTLE;
    end else if (tick) begin
      if (phase == PH_SETTLE) begin
        phase <= PH_SAMPLE;
      end else begin
        code <= final_code;
        if (bitpos != '0) begin
          bitpos <= bitpos - 1'b1;
          phase  <= PH_SETTLE;
        end
      end
    end
  end
endmodule

// File: rtl/scal_store.sv
module scal_store
  import scal_pkg::*;
#(
  parameter int DEPTH  = 132,
  parameter int ADDR_W = 8,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cal_we,
  input  logic [ADDR_W-1:0] cal_addr,
  input  logic [TRIM_W-1:0] cal_data,
  input  logic              host_we,
  input  logic [ADDR_W-1:0] host_addr,
  input  logic [TRIM_W-1:0] host_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [TRIM_W-1:0] rd_data
);
  logic [TRIM_W-1:0] mem [DEPTH];

  function automatic logic in_map(input logic [ADDR_W-1:0] a);
    return (a != '0) && (int'(a) <= DEPTH);
  endfunction

  function automatic logic [IDX_W-1:0] to_idx(input logic [ADDR_W-1:0] a);
    return IDX_W'(a - 1'b1);
  endfunction

  assign rd_data = in_map(rd_addr) ? mem[to_idx(rd_addr)] : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else if (cal_we && in_map(cal_addr)) begin
      mem[to_idx(cal_addr)] <= cal_data;
    end else if (host_we && in_map(host_addr)) begin
      mem[to_idx(host_addr)] <= host_data;
    end
  end
endmodule

// File: rtl/selfcal_seq.sv
module selfcal_seq
  import scal_pkg::*;
#(
  parameter int N_SEG        = 128,
  parameter int N_GAIN       = 4,
  parameter int DIV_BASE_LOG = 5,
  parameter int SEL_W        = 3,
  localparam int DEPTH       = N_SEG + N_GAIN,
  localparam int ADDR_W      = $clog2(DEPTH + 1),
  localparam int SEG_W       = $clog2(N_SEG)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cal_go,
  input  logic [SEL_W-1:0]  div_sel,
  input  logic              cmp_low,
  input  logic              host_we,
  input  logic [ADDR_W-1:0] host_addr,
  input  logic [TRIM_W-1:0] host_wdata,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [TRIM_W-1:0] rd_data,
  output logic              busy,
  output logic              done,
  output logic              blank,
  output logic [ADDR_W-1:0] seg_idx,
  output logic [TRIM_W-1:0] trim_code,
  output logic              mstate_wr,
  output logic [1:0]        mstate_code
);
  logic             go_q;
  logic [SEG_W-1:0] seg;
  logic             start_evt;
  logic             last_seg;
  logic             cal_tick;
  logic             sar_load;
  logic             sar_finish;
  logic [TRIM_W-1:0] sar_final;
  logic             cal_we;
  logic             host_ok;

  assign start_evt   = go_q && !cal_go && !busy;
  assign last_seg    = (seg == SEG_W'(N_SEG - 1));
  assign sar_load    = start_evt || (sar_finish && !last_seg);
  assign cal_we      = sar_finish;
  assign host_ok     = host_we && !busy;
  assign seg_idx     = ADDR_W'(seg) + 1'b1;
  assign blank       = busy;
  assign mstate_code = MSTATE_SELF;

  scal_tick #(.BASE_LOG(DIV_BASE_LOG), .SEL_W(SEL_W)) u_tick (
    .clk  (clk),
    .rst_n(rst_n),
    .run  (busy),
    .sel  (div_sel),
    .tick (cal_tick)
  );

  scal_sar u_sar (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (sar_load),
    .tick      (cal_tick),
    .cmp_low   (cmp_low),
    .code      (trim_code),
    .final_code(sar_final),
    .finish    (sar_finish)
  );

  scal_store #(.DEPTH(DEPTH), .ADDR_W(ADDR_W)) u_store (
    .clk      (clk),
    .rst_n    (rst_n),
    .cal_we   (cal_we),
    .cal_addr (seg_idx),
    .cal_data (sar_final),
    .host_we  (host_ok),
    .host_addr(host_addr),
    .host_data(host_wdata),
    .rd_addr  (rd_addr),
    .rd_data  (rd_data)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      go_q      <= 1'b0;
      busy      <= 1'b0;
      done      <= 1'b0;
      seg       <= '0;
      mstate_wr <= 1'b0;
    end else begin
      go_q      <= cal_go;
      mstate_wr <= 1'b0;
      if (start_evt) begin
        busy <= 1'b1;
        done <= 1'b0;
        seg  <= '0;
      end else if (sar_finish) begin
        if (last_seg) begin
          busy      <= 1'b0;
          done      <= 1'b1;
          mstate_wr <= 1'b1;
        end else begin
          seg <= seg + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/scal_chk.sv
module scal_chk #(
  parameter int N_SEG  = 128,
  parameter int ADDR_W = 8,
  parameter int TW     = 6
) (
  input logic              clk,
  input logic              rst_n,
  input logic              busy,
  input logic              done,
  input logic [ADDR_W-1:0] seg_idx,
  input logic [TW-1:0]     trim_code,
  input logic              cal_tick,
  input logic              cal_we,
  input logic [ADDR_W-1:0] cal_addr,
  input logic              mstate_wr,
  input logic [1:0]        mstate_code
);
  // R7
  busy_done_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(busy && done));

  // R6
  seg_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> (seg_idx == $past(seg_idx) || seg_idx == $past(seg_idx) + 1'b1));

  // R4
  trim_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(busy) && !$past(cal_tick)) |-> (trim_code == $past(trim_code)));

  // R8
  gain_untouched_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cal_we |-> (cal_addr != '0 && int'(cal_addr) <= N_SEG));

  // R7
  done_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> ($past(busy) && mstate_wr && mstate_code == 2'b01));

  // R2
  done_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(done) |-> $rose(busy));

  // R7
  mstate_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mstate_wr |=> !mstate_wr);
endmodule

bind selfcal_seq scal_chk #(.N_SEG(N_SEG), .ADDR_W(ADDR_W), .TW(scal_pkg::TRIM_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .busy       (busy),
  .done       (done),
  .seg_idx    (seg_idx),
  .trim_code  (trim_code),
  .cal_tick   (cal_tick),
  .cal_we     (cal_we),
  .cal_addr   (seg_idx),
  .mstate_wr  (mstate_wr),
  .mstate_code(mstate_code)
);

// File: tb/selfcal_seq_tb.sv
`timescale 1ns/1ps
module selfcal_seq_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cal_go = 1'b0;
  logic [2:0] div_sel = 3'd0;
  logic       cmp_low;
  logic       host_we = 1'b0;
  logic [7:0] host_addr = '0;
  logic [5:0] host_wdata = '0;
  logic [7:0] rd_addr = '0;
  logic [5:0] rd_data;
  logic       busy, done, blank, mstate_wr;
  logic [7:0] seg_idx;
  logic [5:0] trim_code;
  logic [1:0] mstate_code;

  int checks = 0;
  int errors = 0;
  int cur = 0;
  int bias = 11;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  selfcal_seq u_dut (
    .clk(clk), .rst_n(rst_n), .cal_go(cal_go), .div_sel(div_sel), .cmp_low(cmp_low),
    .host_we(host_we), .host_addr(host_addr), .host_wdata(host_wdata),
    .rd_addr(rd_addr), .rd_data(rd_data), .busy(busy), .done(done), .blank(blank),
    .seg_idx(seg_idx), .trim_code(trim_code), .mstate_wr(mstate_wr), .mstate_code(mstate_code)
  );

  // Comparator model: each segment balances at a target code.
  function automatic int tgt(input int a, input int b);
    return (a * 37 + b) % 64;
  endfunction
  assign cmp_low = (int'(trim_code) <= tgt(int'(seg_idx), bias));

  // Host vectors: address, data written, expected read-back.
  typedef struct packed { logic [7:0] addr; logic [5:0] data; logic [5:0] exp; } hv_t;
  localparam hv_t HV [8] = '{
    '{8'd129, 6'd5,  6'd5},  '{8'd130, 6'd40, 6'd40}, '{8'd131, 6'd63, 6'd63},
    '{8'd132, 6'd1,  6'd1},  '{8'd1,   6'd17, 6'd17}, '{8'd128, 6'd44, 6'd44},
    '{8'd0,   6'd9,  6'd0},  '{8'd133, 6'd22, 6'd0}
  };

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic run_to(input int off);
    repeat (off - cur) @(posedge clk);
    #1;
    cur = off;
  endtask

  task automatic start_run();
    cal_go = 1'b1;
    @(posedge clk); #1;
    cal_go = 1'b0;
    @(posedge clk); #1;
    cur = 0;
  endtask

  task automatic host_write(input logic [7:0] a, input logic [5:0] d);
    host_we = 1'b1; host_addr = a; host_wdata = d;
    run_to(cur + 1);
    host_we = 1'b0;
  endtask

  task automatic read_word(input logic [7:0] a, output int v);
    rd_addr = a;
    #0.1;
    v = int'(rd_data);
  endtask

  task automatic full_run(input int p, input int b);
    int v;
    int bad;
    int first;
    bias = b;
    start_run();
    // R2: one edge after the start edge
    check(busy == 1'b1 && blank == 1'b1, "R2 busy/blank", {busy, blank}, 3);
    check(done == 1'b0, "R2 done cleared", done, 0);
    check(seg_idx == 8'd1 && trim_code == 6'd32, "R2 first trial", trim_code, 32);
    // R4: second tick of segment 1 resolves bit 5 and raises bit 4
    first = (32 <= tgt(1, b)) ? 48 : 16;
    run_to(2 * p - 1);
    check(trim_code == 6'd32, "R4 code held before tick", trim_code, 32);
    run_to(2 * p);
    check(int'(trim_code) == first, "R4 code at tick", trim_code, first);
    // R3: ignored start pulse during the run
    cal_go = 1'b1; run_to(cur + 1); cal_go = 1'b0; run_to(cur + 1);
    // R8: host write while busy has no effect
    host_write(8'd130, 6'd3);
    read_word(8'd130, v);
    check(v == 40, "R8 host write ignored while busy", v, 40);
    // R6: segment advance after 12 ticks
    run_to(12 * p - 1);
    check(seg_idx == 8'd1, "R6 still segment 1", seg_idx, 1);
    run_to(12 * p);
    check(seg_idx == 8'd2 && trim_code == 6'd32, "R6 segment 2 begins", seg_idx, 2);
    // R7 and R3: completion exactly on schedule
    run_to(1536 * p - 1);
    check(busy == 1'b1 && done == 1'b0, "R3 run not cut short", done, 0);
    run_to(1536 * p);
    check(done == 1'b1 && busy == 1'b0 && blank == 1'b0, "R7 completion", {done, busy, blank}, 4);
    check(mstate_wr == 1'b1 && mstate_code == 2'b01, "R7 state write", {mstate_wr, mstate_code}, 5);
    run_to(cur + 1);
    check(mstate_wr == 1'b0 && done == 1'b1, "R7 pulse one cycle", {mstate_wr, done}, 1);
    // R5: every linearity word holds its balance code
    bad = 0;
    for (int a = 1; a <= 128; a++) begin
      read_word(8'(a), v);
      if (v != tgt(a, b)) begin
        if (bad == 0) check(1'b0, "R5 segment result", v, tgt(a, b));
        bad++;
      end
    end
    if (bad == 0) check(1'b1, "R5 segment result", 0, 0);
    // R8: gain words untouched
    for (int g = 0; g < 4; g++) begin
      read_word(HV[g].addr, v);
      check(v == int'(HV[g].exp), "R8 gain word kept", v, HV[g].exp);
    end
  endtask

  initial begin
    int v;
    repeat (3) @(posedge clk);
    #1;
    rst_n = 1'b1;
    check(busy == 0 && done == 0 && blank == 0 && mstate_wr == 0, "R1 idle outputs",
          {busy, done, blank, mstate_wr}, 0);
    read_word(8'd77, v);
    check(v == 0, "R1 word cleared", v, 0);
    read_word(8'd132, v);
    check(v == 0, "R1 gain word cleared", v, 0);

    // R9: host vector table
    for (int i = 0; i < 8; i++) begin
      host_write(HV[i].addr, HV[i].data);
      read_word(HV[i].addr, v);
      check(v == int'(HV[i].exp), "R9 host access", v, HV[i].exp);
    end
    // R2: a level high without a falling edge does not start
    cal_go = 1'b1;
    run_to(cur + 3);
    check(busy == 1'b0, "R2 no start on level", busy, 0);
    cal_go = 1'b0;
    run_to(cur + 1);
    // drain the pending falling edge observation is a start: let it run
    check(busy == 1'b1, "R2 start on falling edge", busy, 1);
    // reset to idle again for the timed runs
    rst_n = 1'b0; #1; rst_n = 1'b1;
    for (int i = 0; i < 4; i++) host_write(HV[i].addr, HV[i].data);

    div_sel = 3'd0;
    full_run(32, 11);
    div_sel = 3'd1;
    full_run(64, 50);

    finished = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule